// File: doc/BRIEF.md
# Cluster Coherence Directory Controller

This controller serves one level of a tree of caches. Below it sits a small cluster of child caches, four by default, and above it sits one parent level. For each block it holds, the controller keeps a 3-bit coherence state and a sharer bit vector with one bit per child. Reads and writes from the children arrive over one valid/ready request channel per child. Invalidations go out to children on their own valid/ready channels, and acknowledgements come back as single-cycle pulses. Grants return to the requester over a valid/ready channel.

Towards the parent, the controller issues fetch requests. A fetch is either a plain read or a read-for-ownership. The parent answers with a single-cycle response pulse. The controller also sends a "block dirty" notification upward the first time a child writes a block that this level held only in shared form. Inside the cluster, writes are treated as write-through, so this level itself becomes the dirty holder. The parent then marks the block as modified below it.

The controller handles one transaction at a time. A transaction runs from the accepted request, through any parent fetch and any invalidation round, to the grant and an optional dirty notification. The state array is direct-mapped and indexed by the low address bits. Replacement, routing and the data payload are outside this block.

Top module: `cluster_dir_ctrl`

## Requirements
- R1: After reset, no grant, invalidation, parent request or dirty notification is valid, and every block reads as invalid. Valid state encodings are 001 (shared) and 1X1 (a descendant holds a modified copy); every other code is treated as invalid.
- R2: A read that misses sends one parent request with `p_req_rfo`=0 and the block address. After the parent response, the read is granted (`c_gnt_write`=0) to the requester, with the same address on `c_gnt_addr`. A later read of that block by another child needs no parent request.
- R3: A write to a block held in state 001 sends one invalidation to each other child whose sharer bit is set. It sends none to the requester and none to children without a copy.
- R4: The grant is issued only after an acknowledgement has arrived from every invalidated child. Acknowledgements from children that were not invalidated, or that arrive outside an invalidation round, are ignored.
- R5: A request that hits and needs no invalidation is granted in the cycle right after it is accepted.
- R6: A write hit on a block in state 001 moves it to 1X1 and sends exactly one dirty notification to the parent with the block address, after the grant. No notification is sent if the block was already 1X1. The notification holds valid and address until the parent accepts it.
- R7: After a write grant, the sharer vector holds only the writer. A later write by another child therefore invalidates exactly the previous writer.
- R8: From the accepted request until its grant has been taken and any notification sent, `c_req_ready` stays low for every child.
- R9: A write that misses first sends a parent request with `p_req_rfo`=1. No invalidation and no grant occurs before the parent response, and no dirty notification follows.
- R10: A read of a block in state 1X1 invalidates every other holder before a shared grant, with no parent traffic. Afterwards only the reader is recorded as a sharer.
- R11: When several children request at once, they are served round-robin. The search starts with the child after the last one served; after reset, child 0 comes first. At most one `c_req_ready` bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_req_valid | input | N_CHILD | Per-child request valid |
| c_req_ready | output | N_CHILD | Per-child request ready |
| c_req_write | input | N_CHILD | Per-child request kind, 1 = write |
| c_req_addr | input | N_CHILD*ADDR_W | Per-child block address, child i in slice i |
| c_gnt_valid | output | N_CHILD | Grant valid, one-hot on the requester |
| c_gnt_ready | input | N_CHILD | Per-child grant ready |
| c_gnt_write | output | 1 | Grant is exclusive (write) |
| c_gnt_addr | output | ADDR_W | Granted block address |
| c_inv_valid | output | N_CHILD | Per-child invalidation valid |
| c_inv_ready | input | N_CHILD | Per-child invalidation ready |
| c_inv_addr | output | ADDR_W | Address being invalidated |
| c_ack_valid | input | N_CHILD | Per-child invalidation acknowledgement pulse |
| p_req_valid | output | 1 | Parent fetch request valid |
| p_req_ready | input | 1 | Parent fetch request ready |
| p_req_rfo | output | 1 | Fetch is a read-for-ownership |
| p_req_addr | output | ADDR_W | Fetch address |
| p_rsp_valid | input | 1 | Parent response pulse |
| p_dirty_valid | output | 1 | Dirty notification valid |
| p_dirty_ready | input | 1 | Dirty notification ready |
| p_dirty_addr | output | ADDR_W | Dirty block address |

## Verification
A directed chain on a single block walks it through miss, shared hit, the first write, a second writer and then a reader of the modified block. This separates the invalidation targets, the notification rule and the sharer reset after a grant. A write miss with a slow parent response shows that nothing moves down the tree before the parent answers. Three children requesting at once show the rotating service order. A long random run then mixes children, kinds and eight blocks, with delayed acknowledgements and stray acknowledgement pulses. In that run, premature grants and miscounted acknowledgements show up against a bench model of state and sharers.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

  localparam logic [2:0] ST_INV = 3'b000;
  localparam logic [2:0] ST_SHR = 3'b001;
  localparam logic [2:0] ST_MOD = 3'b101;

  typedef enum logic [2:0] {
    F_IDLE,
    F_PREQ,
    F_PWAIT,
    F_INVAL,
    F_GRANT,
    F_NOTE
  } cdir_fsm_e;

  // shared or modified-below; all other codes read as invalid
  function automatic logic st_valid(input logic [2:0] s);
    return (s == ST_SHR) || (s[2] && s[0]);
  endfunction

  function automatic logic st_mod(input logic [2:0] s);
    return s[2] && s[0];
  endfunction

endpackage

// File: rtl/cdir_rr_arb.sv
module cdir_rr_arb #(
  parameter int N_CHILD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CHILD-1:0] req,
  input  logic               adv,
  output logic [N_CHILD-1:0] gnt
);

  localparam int IW = (N_CHILD > 1) ? $clog2(N_CHILD) : 1;

  logic [IW-1:0] last_q, last_d;
  logic          found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int k = 1; k <= N_CHILD; k++) begin
      int j;
      j = (int'(last_q) + k) % N_CHILD;
      if (!found && req[j]) begin
        gnt[j] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (adv) begin
      for (int i = 0; i < N_CHILD; i++) begin
        if (gnt[i]) last_d = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N_CHILD - 1);
    else if (adv) last_q <= last_d;
  end

endmodule

// File: rtl/cdir_array.sv
module cdir_array #(
  parameter int N_SETS  = 8,
  parameter int TAG_W   = 5,
  parameter int N_CHILD = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(N_SETS)-1:0]  rd_idx,
  output logic [2:0]                 rd_state,
  output logic [TAG_W-1:0]           rd_tag,
  output logic [N_CHILD-1:0]         rd_shr,
  input  logic                       wr_en,
  input  logic [$clog2(N_SETS)-1:0]  wr_idx,
  input  logic [2:0]                 wr_state,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [N_CHILD-1:0]         wr_shr
);

  logic [2:0]         st_q  [N_SETS];
  logic [TAG_W-1:0]   tag_q [N_SETS];
  logic [N_CHILD-1:0] shr_q [N_SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SETS; s++) begin
        st_q[s]  <= 3'b000;
        tag_q[s] <= '0;
        shr_q[s] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]  <= wr_state;
      tag_q[wr_idx] <= wr_tag;
      shr_q[wr_idx] <= wr_shr;
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_shr   = shr_q[rd_idx];

endmodule

// File: rtl/cdir_ack_tracker.sv
module cdir_ack_tracker #(
  parameter int N_CHILD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_CHILD-1:0] load_mask,
  input  logic [N_CHILD-1:0] inv_ready,
  input  logic [N_CHILD-1:0] ack,
  output logic [N_CHILD-1:0] inv_valid,
  output logic               last
);

  localparam int CW = $clog2(N_CHILD + 1);

  logic [N_CHILD-1:0] todo_q, todo_d, wait_q, wait_d, sent, got;
  logic [CW-1:0]      cnt_q, cnt_d, cnt_dec;

  function automatic logic [CW-1:0] pop(input logic [N_CHILD-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = 0; i < N_CHILD; i++) r = r + CW'(v[i]);
    return r;
  endfunction

  assign sent    = todo_q & inv_ready;
  assign got     = wait_q & ack;       // only children already invalidated count
  assign cnt_dec = pop(got);

  always_comb begin
    if (load) begin
      todo_d = load_mask;
      wait_d = '0;
      cnt_d  = pop(load_mask);
    end else begin
      todo_d = todo_q & ~sent;
      wait_d = (wait_q | sent) & ~got;
      cnt_d  = cnt_q - cnt_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      todo_q <= '0;
      wait_q <= '0;
      cnt_q  <= '0;
    end else begin
      todo_q <= todo_d;
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
    end
  end

  assign inv_valid = todo_q;
  assign last      = (cnt_q != '0) && (cnt_q == cnt_dec);

endmodule

// File: rtl/cluster_dir_ctrl.sv
module cluster_dir_ctrl
  import cdir_pkg::*;
#(
  parameter int N_CHILD = 4,
  parameter int ADDR_W  = 8,
  parameter int N_SETS  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CHILD-1:0]          c_req_valid,
  output logic [N_CHILD-1:0]          c_req_ready,
  input  logic [N_CHILD-1:0]          c_req_write,
  input  logic [N_CHILD*ADDR_W-1:0]   c_req_addr,
  output logic [N_CHILD-1:0]          c_gnt_valid,
  input  logic [N_CHILD-1:0]          c_gnt_ready,
  output logic                        c_gnt_write,
  output logic [ADDR_W-1:0]           c_gnt_addr,
  output logic [N_CHILD-1:0]          c_inv_valid,
  input  logic [N_CHILD-1:0]          c_inv_ready,
  output logic [ADDR_W-1:0]           c_inv_addr,
  input  logic [N_CHILD-1:0]          c_ack_valid,
  output logic                        p_req_valid,
  input  logic                        p_req_ready,
  output logic                        p_req_rfo,
  output logic [ADDR_W-1:0]           p_req_addr,
  input  logic                        p_rsp_valid,
  output logic                        p_dirty_valid,
  input  logic                        p_dirty_ready,
  output logic [ADDR_W-1:0]           p_dirty_addr
);

  localparam int IDX_W = $clog2(N_SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  cdir_fsm_e          fsm_q, fsm_d;
  logic [N_CHILD-1:0] cur_req_q;
  logic               cur_wr_q;
  logic [ADDR_W-1:0]  cur_addr_q;
  logic               cur_hit_q;
  logic [2:0]         cur_state_q;
  logic [N_CHILD-1:0] cur_shr_q;

  logic [N_CHILD-1:0] arb_gnt;
  logic               accept;
  logic               sel_wr;
  logic [ADDR_W-1:0]  sel_addr;
  logic [2:0]         rd_state, sel_state;
  logic [TAG_W-1:0]   rd_tag;
  logic [N_CHILD-1:0] rd_shr, sel_shr, sel_targets;
  logic               sel_hit;

  logic               gnt_done, note_needed, inv_last;
  logic [2:0]         new_state;
  logic [N_CHILD-1:0] new_shr;

  // ---------------- request selection ----------------
  assign accept = (fsm_q == F_IDLE) && |(c_req_valid & arb_gnt);

  cdir_rr_arb #(.N_CHILD(N_CHILD)) u_arb (
    .clk   (clk),
    .rst_n (rst_i),
    .req   (c_req_valid),
    .adv   (accept),
    .gnt   (arb_gnt)
  );

  always_comb begin
    sel_wr   = 1'b0;
    sel_addr = '0;
    for (int i = 0; i < N_CHILD; i++) begin
      if (arb_gnt[i]) begin
        sel_wr   = sel_wr | c_req_write[i];
        sel_addr = sel_addr | c_req_addr[i*ADDR_W +: ADDR_W];
      end
    end
  end

  assign c_req_ready = (fsm_q == F_IDLE) ? arb_gnt : '0;

  // ---------------- directory lookup ----------------
  cdir_array #(.N_SETS(N_SETS), .TAG_W(TAG_W), .N_CHILD(N_CHILD)) u_array (
    .clk      (clk),
    .rst_n    (rst_i),
    .rd_idx   (sel_addr[IDX_W-1:0]),
    .rd_state (rd_state),
    .rd_tag   (rd_tag),
    .rd_shr   (rd_shr),
    .wr_en    (gnt_done),
    .wr_idx   (cur_addr_q[IDX_W-1:0]),
    .wr_state (new_state),
    .wr_tag   (cur_addr_q[ADDR_W-1:IDX_W]),
    .wr_shr   (new_shr)
  );

  assign sel_hit     = st_valid(rd_state) && (rd_tag == sel_addr[ADDR_W-1:IDX_W]);
  assign sel_state   = sel_hit ? rd_state : ST_INV;
  assign sel_shr     = sel_hit ? rd_shr : '0;
  assign sel_targets = (sel_wr || st_mod(sel_state)) ? (sel_shr & ~arb_gnt) : '0;

  // ---------------- invalidation round ----------------
  cdir_ack_tracker #(.N_CHILD(N_CHILD)) u_acks (
    .clk       (clk),
    .rst_n     (rst_i),
    .load      (accept),
    .load_mask (sel_targets),
    .inv_ready (c_inv_ready),
    .ack       (c_ack_valid),
    .inv_valid (c_inv_valid),
    .last      (inv_last)
  );

  // ---------------- update values ----------------
  assign gnt_done    = (fsm_q == F_GRANT) && |(cur_req_q & c_gnt_ready);
  assign note_needed = cur_wr_q && cur_hit_q && !st_mod(cur_state_q);

  always_comb begin
    if (cur_wr_q)       new_state = st_mod(cur_state_q) ? cur_state_q : ST_MOD;
    else if (cur_hit_q) new_state = cur_state_q;
    else                new_state = ST_SHR;
  end

  always_comb begin
    if (cur_wr_q || !cur_hit_q || st_mod(cur_state_q)) new_shr = cur_req_q;
    else                                              new_shr = cur_shr_q | cur_req_q;
  end

  // ---------------- control ----------------
  always_comb begin
    fsm_d = fsm_q;
    unique case (fsm_q)
      F_IDLE: begin
        if (accept) begin
          if (!sel_hit)           fsm_d = F_PREQ;
          else if (|sel_targets)  fsm_d = F_INVAL;
          else                    fsm_d = F_GRANT;
        end
      end
      F_PREQ:  if (p_req_ready) fsm_d = F_PWAIT;
      F_PWAIT: if (p_rsp_valid) fsm_d = F_GRANT;
      F_INVAL: if (inv_last)    fsm_d = F_GRANT;
      F_GRANT: if (gnt_done)    fsm_d = note_needed ? F_NOTE : F_IDLE;
      F_NOTE:  if (p_dirty_ready) fsm_d = F_IDLE;
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) fsm_q <= F_IDLE;
    else        fsm_q <= fsm_d;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cur_req_q   <= '0;
      cur_wr_q    <= 1'b0;
      cur_addr_q  <= '0;
      cur_hit_q   <= 1'b0;
      cur_state_q <= ST_INV;
      cur_shr_q   <= '0;
    end else if (accept) begin
      cur_req_q   <= arb_gnt;
      cur_wr_q    <= sel_wr;
      cur_addr_q  <= sel_addr;
      cur_hit_q   <= sel_hit;
      cur_state_q <= sel_state;
      cur_shr_q   <= sel_shr;
    end
  end

  // ---------------- outputs ----------------
  assign c_gnt_valid   = (fsm_q == F_GRANT) ? cur_req_q : '0;
  assign c_gnt_write   = cur_wr_q;
  assign c_gnt_addr    = cur_addr_q;
  assign c_inv_addr    = cur_addr_q;
  assign p_req_valid   = (fsm_q == F_PREQ);
  assign p_req_rfo     = cur_wr_q;
  assign p_req_addr    = cur_addr_q;
  assign p_dirty_valid = (fsm_q == F_NOTE);
  assign p_dirty_addr  = cur_addr_q;

endmodule

// File: rtl/cdir_checker.sv
module cdir_checker #(
  parameter int N_CHILD = 4,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CHILD-1:0] c_req_ready,
  input logic [N_CHILD-1:0] c_gnt_valid,
  input logic [N_CHILD-1:0] c_gnt_ready,
  input logic [N_CHILD-1:0] c_inv_valid,
  input logic               p_req_valid,
  input logic               p_dirty_valid,
  input logic               p_dirty_ready,
  input logic [ADDR_W-1:0]  p_dirty_addr,
  input logic [N_CHILD-1:0] cur_req
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(c_gnt_valid)); // R2

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(c_gnt_valid & ~c_gnt_ready)) |=> (c_gnt_valid == $past(c_gnt_valid))); // R2

  AST_INV_NOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|c_inv_valid) |-> ((c_inv_valid & cur_req) == '0)); // R3

  AST_NO_GNT_DURING_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (|c_inv_valid) |-> (c_gnt_valid == '0)); // R4

  AST_DIRTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (p_dirty_valid && !p_dirty_ready) |=> (p_dirty_valid && $stable(p_dirty_addr))); // R6

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((|c_gnt_valid) || (|c_inv_valid) || p_req_valid || p_dirty_valid) |-> (c_req_ready == '0)); // R8

  AST_PARENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    p_req_valid |-> ((c_gnt_valid == '0) && (c_inv_valid == '0))); // R9

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(c_req_ready)); // R11

endmodule

bind cluster_dir_ctrl cdir_checker #(.N_CHILD(N_CHILD), .ADDR_W(ADDR_W)) u_cdir_checker (
  .clk           (clk),
  .rst_n         (rst_i),
  .c_req_ready   (c_req_ready),
  .c_gnt_valid   (c_gnt_valid),
  .c_gnt_ready   (c_gnt_ready),
  .c_inv_valid   (c_inv_valid),
  .p_req_valid   (p_req_valid),
  .p_dirty_valid (p_dirty_valid),
  .p_dirty_ready (p_dirty_ready),
  .p_dirty_addr  (p_dirty_addr),
  .cur_req       (cur_req_q)
);

// File: tb/cluster_dir_ctrl_bench.sv
`timescale 1ns/1ps
module cluster_dir_ctrl_bench;

  localparam int N  = 4;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    c_req_valid = '0, c_req_ready, c_req_write = '0;
  logic [N*AW-1:0] c_req_addr = '0;
  logic [N-1:0]    c_gnt_valid, c_gnt_ready = '1;
  logic            c_gnt_write;
  logic [AW-1:0]   c_gnt_addr, c_inv_addr;
  logic [N-1:0]    c_inv_valid, c_inv_ready = '1, c_ack_valid = '0;
  logic            p_req_valid, p_req_ready = 1'b1, p_req_rfo;
  logic [AW-1:0]   p_req_addr, p_dirty_addr;
  logic            p_rsp_valid = 1'b0, p_dirty_valid, p_dirty_ready = 1'b1;

  always #2 clk = ~clk;

  cluster_dir_ctrl #(.N_CHILD(N), .ADDR_W(AW), .N_SETS(8)) u_cluster_dir_ctrl (
    .clk(clk), .rst_n(rst_n),
    .c_req_valid(c_req_valid), .c_req_ready(c_req_ready),
    .c_req_write(c_req_write), .c_req_addr(c_req_addr),
    .c_gnt_valid(c_gnt_valid), .c_gnt_ready(c_gnt_ready),
    .c_gnt_write(c_gnt_write), .c_gnt_addr(c_gnt_addr),
    .c_inv_valid(c_inv_valid), .c_inv_ready(c_inv_ready), .c_inv_addr(c_inv_addr),
    .c_ack_valid(c_ack_valid),
    .p_req_valid(p_req_valid), .p_req_ready(p_req_ready),
    .p_req_rfo(p_req_rfo), .p_req_addr(p_req_addr),
    .p_rsp_valid(p_rsp_valid),
    .p_dirty_valid(p_dirty_valid), .p_dirty_ready(p_dirty_ready),
    .p_dirty_addr(p_dirty_addr)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit run = 1'b0, stray_en = 1'b0, busy = 1'b0;

  // transaction logs, cleared at each accept
  logic [N-1:0] inv_log;
  int par_cnt, par_rfo, par_addr, dirty_cnt, dirty_addr;
  int gnt_wr, gnt_addr_l, gnt_delay, acc_cyc, out_acks, rsp_tmr;
  bit par_out;
  int ack_tmr [N];
  int gnt_cnt [N];
  int order [64];
  int n_order = 0;

  // bench model: 0 invalid, 1 shared, 2 modified below
  int           m_st [8];
  logic [N-1:0] m_sh [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic ck(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // child/parent responder and observer, acts 1ns after each falling edge
  initial begin
    for (int i = 0; i < N; i++) begin ack_tmr[i] = 0; gnt_cnt[i] = 0; end
    out_acks = 0; rsp_tmr = 0; par_out = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (run) begin
        if (busy) ck("R8 ready low while busy", int'(c_req_ready), 0);
        if ((c_req_valid & c_req_ready) != '0) begin
          acc_cyc = cyc; busy = 1'b1; inv_log = '0; par_cnt = 0; par_rfo = 0;
          par_addr = 0; dirty_cnt = 0; dirty_addr = 0;
        end
        for (int i = 0; i < N; i++) begin
          if (c_inv_valid[i]) begin
            if (par_out) ck("R9 no invalidation before parent response", 1, 0);
            inv_log[i] = 1'b1;
            ack_tmr[i] = 2 + int'($urandom % 3);
            out_acks++;
          end
        end
        if (p_req_valid) begin
          par_cnt++; par_rfo = int'(p_req_rfo); par_addr = int'(p_req_addr);
          rsp_tmr = 2 + int'($urandom % 4); par_out = 1'b1;
        end
        if (c_gnt_valid != '0) begin
          for (int i = 0; i < N; i++) if (c_gnt_valid[i]) begin
            gnt_cnt[i]++; order[n_order % 64] = i; n_order++;
          end
          gnt_wr = int'(c_gnt_write); gnt_addr_l = int'(c_gnt_addr);
          gnt_delay = cyc - acc_cyc;
          ck("R4 all acks in before grant", out_acks, 0);
          ck("R9 parent answered before grant", int'(par_out), 0);
          busy = 1'b0;
        end
        if (p_dirty_valid && p_dirty_ready) begin
          dirty_cnt++; dirty_addr = int'(p_dirty_addr);
        end
      end
      // drive responses
      for (int i = 0; i < N; i++) begin
        if (ack_tmr[i] > 0) begin
          ack_tmr[i]--;
          c_ack_valid[i] = (ack_tmr[i] == 0);
          if (ack_tmr[i] == 0) out_acks--;
        end else begin
          c_ack_valid[i] = stray_en ? 1'($urandom % 2) : 1'b0;
        end
      end
      if (rsp_tmr > 0) begin
        rsp_tmr--;
        p_rsp_valid = (rsp_tmr == 0);
        if (rsp_tmr == 0) par_out = 1'b0;
      end else p_rsp_valid = 1'b0;
    end
  end

  task automatic do_txn(int c, bit wr, int a);
    int g;
    g = gnt_cnt[c];
    @(negedge clk);
    c_req_valid[c] = 1'b1;
    c_req_write[c] = wr;
    c_req_addr[c*AW +: AW] = AW'(a);
    #1;
    while (!c_req_ready[c]) begin @(negedge clk); #1; end
    @(negedge clk);
    c_req_valid[c] = 1'b0;
    while (gnt_cnt[c] == g) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic apply(int c, bit wr, int a);
    logic [N-1:0] me;
    me = N'(1) << c;
    if (wr || m_st[a] != 1) m_sh[a] = me; else m_sh[a] = m_sh[a] | me;
    if (wr) m_st[a] = 2; else if (m_st[a] == 0) m_st[a] = 1;
  endtask

  task automatic txn_chk(int c, bit wr, int a);
    bit miss;
    logic [N-1:0] exp_inv;
    int exp_dirty;
    miss = (m_st[a] == 0);
    exp_inv = (wr || m_st[a] == 2) ? (m_sh[a] & ~(N'(1) << c)) : '0;
    exp_dirty = (wr && m_st[a] == 1) ? 1 : 0;
    do_txn(c, wr, a);
    if (wr) ck("R9 parent request count", par_cnt, int'(miss));
    else    ck("R2 parent request count", par_cnt, int'(miss));
    if (miss) begin
      ck(wr ? "R9 read-for-ownership flag" : "R2 plain read flag", par_rfo, int'(wr));
      ck("R2 parent request address", par_addr, a);
    end
    if (m_st[a] == 2 && !wr)   ck("R10 invalidations on modified read", int'(inv_log), int'(exp_inv));
    else if (m_st[a] == 2)     ck("R7 invalidations of previous writer", int'(inv_log), int'(exp_inv));
    else                       ck("R3 invalidation targets", int'(inv_log), int'(exp_inv));
    ck("R6 dirty notification count", dirty_cnt, exp_dirty);
    if (exp_dirty == 1) ck("R6 dirty notification address", dirty_addr, a);
    ck("R2 grant kind", gnt_wr, int'(wr));
    ck("R2 grant address", gnt_addr_l, a);
    if (!miss && exp_inv == '0) ck("R5 grant one cycle after accept", gnt_delay, 1);
    apply(c, wr, a);
  endtask

  // watchdog
  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'd20240611));
    for (int a = 0; a < 8; a++) begin m_st[a] = 0; m_sh[a] = '0; end
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs idle in reset
    ck("R1 grant idle in reset", int'(c_gnt_valid), 0);
    ck("R1 invalidation idle in reset", int'(c_inv_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    ck("R1 parent request idle", int'(p_req_valid), 0);
    ck("R1 dirty notification idle", int'(p_dirty_valid), 0);
    ck("R1 grant idle", int'(c_gnt_valid), 0);
    run = 1'b1;

    // directed chain on one block
    txn_chk(0, 1'b0, 1);   // R1 R2 read miss
    txn_chk(1, 1'b0, 1);   // R2 R5 shared hit
    txn_chk(2, 1'b1, 1);   // R3 R4 R6 first write
    txn_chk(3, 1'b1, 1);   // R7 second writer, no notify
    txn_chk(0, 1'b0, 1);   // R10 read of modified block
    txn_chk(1, 1'b1, 2);   // R9 write miss
    txn_chk(1, 1'b1, 2);   // R5 owner rewrite

    // R11 round robin: last served is child 1
    txn_chk(1, 1'b0, 5);
    begin
      int base;
      base = n_order;
      fork
        do_txn(0, 1'b0, 6);
        do_txn(2, 1'b0, 7);
        do_txn(3, 1'b0, 4);
      join
      ck("R11 first served", order[base % 64], 2);
      ck("R11 second served", order[(base + 1) % 64], 3);
      ck("R11 third served", order[(base + 2) % 64], 0);
      apply(2, 1'b0, 7); apply(3, 1'b0, 4); apply(0, 1'b0, 6);
    end

    // random phase with stray acknowledgements (R4)
    stray_en = 1'b1;
    for (int t = 0; t < 150; t++) begin
      txn_chk(int'($urandom % N), 1'($urandom % 2), int'($urandom % 8));
    end
    stray_en = 1'b0;

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule